// File: doc/BRIEF.md
# Flash Erase Sequencing Controller

This block steps a nonvolatile array through a block-erase operation under software control. Software writes a control/status word to enter erase mode. It makes one throw-away write to the array as an interlock, then raises the high-voltage-enable bit to start. The controller then drives per-sector erase enables for a fixed number of cycles. At the end it raises a completion flag together with a pass flag, and pulses a commit strobe that tells the array model to turn the enabled sectors to all-ones.

Sectors are chosen with a select mask and a separate lock mask. A sector is erased only when it is selected and not locked. The pair is sampled at the moment the erase starts. A running erase can be aborted by dropping high-voltage-enable, which ends with a fail status. It can also be paused by raising the suspend bit, which reports completion within a bounded time, and later resumed from the point where it stopped. Any control write that breaks the sequencing rules leaves the register unchanged.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After synchronous reset the status word reads 0, no sector enable is asserted, and the busy and commit outputs are low.
- R2: Control bit 2 (erase-select) written as 1 from idle enters erase mode. Bit 0 (high-voltage-enable) takes effect only after exactly one `arr_we` strobe in erase mode; before that strobe a write with bit 0 set is ignored. The array write's address and data are discarded.
- R3: Setting bit 0 after the interlock holds `erase_busy` for exactly T_ERASE cycles. Then bit 10 (done) and bit 9 (pass) are set and `erase_commit` pulses once.
- R4: The sectors enabled during an erase are exactly select AND NOT lock, as sampled at the start write. A selected and locked sector keeps its contents.
- R5: Writing bit 2 as 0 after the interlock but before bit 0 returns to idle and nothing is erased.
- R6: Writing bit 0 as 0 during a running erase stops busy at once and clears pass. Done rises ABT_LAT cycles later, there is no commit, and a new interlock write is needed before the next start.
- R7: Writing bits 2, 1 and 0 all as 1 during a running erase (program bit 4 low) sets suspend (bit 1) and stops busy. Done rises SUS_LAT cycles later, never more than T_ESUS.
- R8: While suspended, an abort write (bit 0 as 0) and array writes are ignored, and no erase activity occurs.
- R9: Writing bit 1 as 0 with bits 2 and 0 as 1 while suspended clears suspend and done and resumes the erase. Busy time over the whole operation totals T_ERASE cycles, followed by done, pass and commit.
- R10: After completion, writing bit 0 as 0 keeps done and pass and returns to erase mode, where a new interlock write is needed. Then writing bit 2 as 0 leaves erase mode.
- R11: A suspend request outside a running erase is ignored. An erase-select write is ignored while the program bit (bit 4) is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| ctl_rdata | output | 16 | Control/status word readback |
| slr_we | input | 1 | Select/lock mask write strobe |
| slr_sel | input | NSEC | Sector select mask |
| slr_lock | input | NSEC | Sector lock mask |
| arr_we | input | 1 | Array write strobe (interlock) |
| arr_addr | input | AW | Array write address (discarded) |
| arr_wdata | input | DW | Array write data (discarded) |
| sec_erase_en | output | NSEC | Per-sector erase enable |
| erase_busy | output | 1 | High while the erase is progressing |
| erase_commit | output | 1 | One-cycle pulse on successful completion |

## Verification
The erase is run with overlapping select and lock masks (0x0E with 0x08), so the locked sector, the unselected sectors and the erased sectors can each be told apart in the array stub. The same start is tried without an interlock, with an abort partway through, with a suspend and resume, and with erase mode abandoned before the start. Comparing measured busy time, done latency and commit count across these runs shows whether a run completed, was paused and continued, or was dropped. The ignored writes are each followed by a status readback, which shows that no bit moved.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam int CTL_W  = 16;
  localparam int HV_B   = 0;
  localparam int SUS_B  = 1;
  localparam int ERS_B  = 2;
  localparam int PGM_B  = 4;
  localparam int PEG_B  = 9;
  localparam int DONE_B = 10;
  localparam logic [CTL_W-1:0] WR_MASK =
    CTL_W'((1 << HV_B) | (1 << SUS_B) | (1 << ERS_B) | (1 << PGM_B));

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_LATCH, ST_ERASE, ST_SWAIT, ST_SUSP, ST_ABORT, ST_FIN
  } fes_state_e;
endpackage

// File: rtl/fes_timer.sv
module fes_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fes_sector_mask.sv
module fes_sector_mask #(
  parameter int NSEC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            slr_we,
  input  logic [NSEC-1:0] slr_sel,
  input  logic [NSEC-1:0] slr_lock,
  input  logic            start,
  input  logic            hold,
  output logic [NSEC-1:0] sel_mask,
  output logic [NSEC-1:0] lock_mask,
  output logic [NSEC-1:0] sec_en
);
  logic [NSEC-1:0] run_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_mask  <= '0;
      lock_mask <= '0;
    end else if (slr_we) begin
      sel_mask  <= slr_sel;
      lock_mask <= slr_lock;
    end
  end

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    logic cand;
    assign cand = sel_mask[s] & ~lock_mask[s];
    always_ff @(posedge clk) begin
      if (rst) begin
        run_mask[s] <= 1'b0;
        sec_en[s]   <= 1'b0;
      end else begin
        if (start) run_mask[s] <= cand;
        sec_en[s] <= hold & (start ? cand : run_mask[s]);
      end
    end
  end
endmodule

// File: rtl/fes_fsm.sv
module fes_fsm
  import fes_pkg::*;
#(
  parameter int T_ERASE = 64,
  parameter int SUS_LAT = 3,
  parameter int ABT_LAT = 4,
  parameter int EW      = 7,
  parameter int PW      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wd,
  input  logic             arr_we,
  input  logic [EW-1:0]    ecnt,
  input  logic [PW-1:0]    pcnt,
  output logic             start,
  output logic             hold,
  output logic             e_run,
  output logic             p_clr,
  output logic             busy,
  output logic             commit,
  output logic [CTL_W-1:0] status
);
  fes_state_e st_q, st_d;
  logic ers_q, ehv_q, sus_q, pgm_q, done_q, peg_q;
  logic ers_d, ehv_d, sus_d, pgm_d, done_d, peg_d, commit_d;
  logic wd_unused;

  assign wd_unused = ^(ctl_wd & ~WR_MASK);

  always_comb begin
    st_d = st_q; ers_d = ers_q; ehv_d = ehv_q; sus_d = sus_q;
    pgm_d = pgm_q; done_d = done_q; peg_d = peg_q; commit_d = 1'b0;
    start = 1'b0;
    unique case (st_q)
      ST_IDLE: if (ctl_we) begin
        if (ctl_wd[ERS_B]) begin
          if (!pgm_q) begin st_d = ST_SEL; ers_d = 1'b1; end
        end else begin
          pgm_d = ctl_wd[PGM_B];
        end
      end
      ST_SEL: begin
        if (ctl_we && !ctl_wd[ERS_B]) begin st_d = ST_IDLE; ers_d = 1'b0; end
        else if (arr_we) st_d = ST_LATCH;
      end
      ST_LATCH: if (ctl_we) begin
        if (!ctl_wd[ERS_B]) begin
          st_d = ST_IDLE; ers_d = 1'b0;
        end else if (ctl_wd[HV_B]) begin
          st_d = ST_ERASE; ehv_d = 1'b1; done_d = 1'b0; peg_d = 1'b0;
          start = 1'b1;
        end
      end
      ST_ERASE: begin
        if (ecnt == EW'(T_ERASE - 1)) begin
          st_d = ST_FIN; done_d = 1'b1; peg_d = 1'b1; commit_d = 1'b1;
        end else if (ctl_we && !ctl_wd[HV_B]) begin
          st_d = ST_ABORT; ehv_d = 1'b0; peg_d = 1'b0;
        end else if (ctl_we && ctl_wd[ERS_B] && ctl_wd[SUS_B] && !sus_q && !pgm_q) begin
          st_d = ST_SWAIT; sus_d = 1'b1;
        end
      end
      ST_SWAIT: if (pcnt == PW'(SUS_LAT - 1)) begin
        st_d = ST_SUSP; done_d = 1'b1;
      end
      ST_SUSP: if (ctl_we && ctl_wd[ERS_B] && ctl_wd[HV_B] && !ctl_wd[SUS_B]) begin
        st_d = ST_ERASE; sus_d = 1'b0; done_d = 1'b0;
      end
      ST_ABORT: if (pcnt == PW'(ABT_LAT - 1)) begin
        st_d = ST_SEL; done_d = 1'b1;
      end
      ST_FIN: if (ctl_we && !ctl_wd[HV_B]) begin
        ehv_d = 1'b0;
        if (ctl_wd[ERS_B]) st_d = ST_SEL;
        else begin st_d = ST_IDLE; ers_d = 1'b0; end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
      {ers_q, ehv_q, sus_q, pgm_q, done_q, peg_q, commit} <= '0;
    end else begin
      st_q <= st_d;
      ers_q <= ers_d; ehv_q <= ehv_d; sus_q <= sus_d;
      pgm_q <= pgm_d; done_q <= done_d; peg_q <= peg_d;
      commit <= commit_d;
    end
  end

  assign hold  = (st_d == ST_ERASE) || commit_d;
  assign e_run = (st_q == ST_ERASE);
  assign busy  = e_run;
  assign p_clr = (st_q != st_d);

  always_comb begin
    status = '0;
    status[HV_B]   = ehv_q;
    status[SUS_B]  = sus_q;
    status[ERS_B]  = ers_q;
    status[PGM_B]  = pgm_q;
    status[PEG_B]  = peg_q;
    status[DONE_B] = done_q;
  end
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import fes_pkg::*;
#(
  parameter int NSEC    = 8,
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int T_ERASE = 64,
  parameter int SUS_LAT = 3,
  parameter int T_ESUS  = 8,
  parameter int ABT_LAT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [15:0]      ctl_wdata,
  output logic [15:0]      ctl_rdata,
  input  logic             slr_we,
  input  logic [NSEC-1:0]  slr_sel,
  input  logic [NSEC-1:0]  slr_lock,
  input  logic             arr_we,
  input  logic [AW-1:0]    arr_addr,
  input  logic [DW-1:0]    arr_wdata,
  output logic [NSEC-1:0]  sec_erase_en,
  output logic             erase_busy,
  output logic             erase_commit
);
  localparam int EW   = $clog2(T_ERASE + 1);
  localparam int PMAX = (SUS_LAT > ABT_LAT) ? SUS_LAT : ABT_LAT;
  localparam int PW   = $clog2(PMAX + 1);

  logic [EW-1:0]   ecnt;
  logic [PW-1:0]   pcnt;
  logic            start, hold, e_run, p_clr;
  logic [NSEC-1:0] sel_mask, lock_mask;
  logic            arr_unused;

  assign arr_unused = ^{arr_addr, arr_wdata};

  fes_fsm #(
    .T_ERASE(T_ERASE), .SUS_LAT(SUS_LAT), .ABT_LAT(ABT_LAT), .EW(EW), .PW(PW)
  ) u_fsm (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wd(ctl_wdata), .arr_we(arr_we),
    .ecnt(ecnt), .pcnt(pcnt), .start(start), .hold(hold), .e_run(e_run),
    .p_clr(p_clr), .busy(erase_busy), .commit(erase_commit), .status(ctl_rdata)
  );

  fes_timer #(.W(EW)) u_erase_tmr (
    .clk(clk), .rst(rst), .clr(start), .en(e_run), .cnt(ecnt)
  );

  fes_timer #(.W(PW)) u_phase_tmr (
    .clk(clk), .rst(rst), .clr(p_clr), .en(1'b1), .cnt(pcnt)
  );

  fes_sector_mask #(.NSEC(NSEC)) u_mask (
    .clk(clk), .rst(rst), .slr_we(slr_we), .slr_sel(slr_sel), .slr_lock(slr_lock),
    .start(start), .hold(hold), .sel_mask(sel_mask), .lock_mask(lock_mask),
    .sec_en(sec_erase_en)
  );
endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
  parameter int NSEC   = 8,
  parameter int T_ESUS = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [15:0]     ctl_rdata,
  input logic            arr_we,
  input logic [NSEC-1:0] sec_erase_en,
  input logic            erase_busy,
  input logic            erase_commit,
  input logic [NSEC-1:0] sel_mask,
  input logic [NSEC-1:0] lock_mask
);
  logic        ilk_q;
  logic [15:0] sus_cnt;

  always_ff @(posedge clk) begin
    if (rst || !ctl_rdata[2] || ctl_rdata[0]) ilk_q <= 1'b0;
    else if (arr_we)                          ilk_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) sus_cnt <= '0;
    else if (ctl_rdata[1] && !ctl_rdata[10]) sus_cnt <= sus_cnt + 16'd1;
    else sus_cnt <= '0;
  end

  AST_START_AFTER_INTERLOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_rdata[0]) |-> $past(ilk_q)); // R2
  AST_COMMIT_WITH_PASS: assert property (@(posedge clk) disable iff (rst)
    erase_commit |-> (ctl_rdata[10] && ctl_rdata[9])); // R3
  AST_START_MASK: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_rdata[0]) |-> (sec_erase_en == ($past(sel_mask) & ~$past(lock_mask)))); // R4
  AST_ABORT_FAILS: assert property (@(posedge clk) disable iff (rst)
    ($rose(ctl_rdata[10]) && !ctl_rdata[0]) |-> !ctl_rdata[9]); // R6
  AST_SUSPEND_BOUND: assert property (@(posedge clk) disable iff (rst)
    sus_cnt <= 16'(T_ESUS)); // R7
  AST_IDLE_IN_SUSPEND: assert property (@(posedge clk) disable iff (rst)
    ctl_rdata[1] |-> (!erase_busy && sec_erase_en == '0)); // R8
endmodule

bind flash_erase_ctrl fes_checker #(.NSEC(NSEC), .T_ESUS(T_ESUS)) u_fes_checker (
  .clk(clk), .rst(rst), .ctl_rdata(ctl_rdata), .arr_we(arr_we),
  .sec_erase_en(sec_erase_en), .erase_busy(erase_busy), .erase_commit(erase_commit),
  .sel_mask(sel_mask), .lock_mask(lock_mask)
);

// File: tb/test_flash_erase_ctrl.sv
`timescale 1ns/100ps
module test_flash_erase_ctrl;
  localparam int NSEC = 8, AW = 16, DW = 32;
  localparam int T_ERASE = 20, SUS_LAT = 3, T_ESUS = 6, ABT_LAT = 2;

  logic clk = 0, rst = 1;
  logic ctl_we = 0, slr_we = 0, arr_we = 0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_rdata;
  logic [NSEC-1:0] slr_sel = '0, slr_lock = '0, sec_erase_en;
  logic [AW-1:0] arr_addr = '0;
  logic [DW-1:0] arr_wdata = '0;
  logic erase_busy, erase_commit;

  int checks = 0, failures = 0;
  int busy_cnt, commit_cnt;
  logic fill_req = 0;
  logic [DW-1:0] mem [NSEC];
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_erase_ctrl #(.NSEC(NSEC), .AW(AW), .DW(DW), .T_ERASE(T_ERASE),
    .SUS_LAT(SUS_LAT), .T_ESUS(T_ESUS), .ABT_LAT(ABT_LAT)) i_flash_erase_ctrl (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .slr_we(slr_we), .slr_sel(slr_sel), .slr_lock(slr_lock), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .sec_erase_en(sec_erase_en),
    .erase_busy(erase_busy), .erase_commit(erase_commit));

  // array stub: fill with a pattern, erase enabled sectors on commit
  always @(posedge clk) begin
    for (int i = 0; i < NSEC; i++) begin
      if (fill_req) mem[i] <= 32'hA500_0000 + i;
      else if (erase_commit && sec_erase_en[i]) mem[i] <= '1;
    end
    if (rst) begin busy_cnt <= 0; commit_cnt <= 0; end
    else begin
      if (erase_busy) busy_cnt <= busy_cnt + 1;
      if (erase_commit) commit_cnt <= commit_cnt + 1;
    end
  end

  function automatic logic [DW-1:0] pat(int i);
    return 32'hA500_0000 + i;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; fill_req = 1;
    repeat (3) @(negedge clk);
    rst = 0; fill_req = 0;
    @(negedge clk);
  endtask

  task automatic ctl_write(logic [15:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic ilk_write();
    @(negedge clk); arr_we = 1; arr_addr = 16'h0040; arr_wdata = 32'h1234_5678;
    @(negedge clk); arr_we = 0;
  endtask

  task automatic slr_write(logic [NSEC-1:0] s, logic [NSEC-1:0] l);
    @(negedge clk); slr_we = 1; slr_sel = s; slr_lock = l;
    @(negedge clk); slr_we = 0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!ctl_rdata[10] && n < 1000);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 status", 32'(ctl_rdata), 0);
    chk("R1 enables", 32'(sec_erase_en), 0);
    chk("R1 busy/commit", {30'd0, erase_busy, erase_commit}, 0);
  endtask

  task automatic t_normal();
    int n;
    do_reset();
    slr_write(8'h0E, 8'h08);
    ctl_write(16'h0004);
    chk("R2 erase mode", 32'(ctl_rdata), 32'h4);
    ctl_write(16'h0005);
    chk("R2 hv before interlock", 32'(ctl_rdata), 32'h4);
    chk("R2 no busy", 32'(erase_busy), 0);
    ilk_write();
    chk("R2 interlock no status change", 32'(ctl_rdata), 32'h4);
    ctl_write(16'h0005);
    chk("R3 started", 32'(ctl_rdata), 32'h5);
    chk("R3 busy", 32'(erase_busy), 1);
    chk("R4 enables", 32'(sec_erase_en), 32'h06);
    wait_done(n);
    chk("R3 duration", n, T_ERASE);
    chk("R3 status", 32'(ctl_rdata), 32'h605);
    @(negedge clk);
    chk("R3 commit count", commit_cnt, 1);
    chk("R4 sector1 erased", mem[1], '1);
    chk("R4 sector2 erased", mem[2], '1);
    chk("R4 locked sector3 kept", mem[3], pat(3));
    chk("R4 unselected sector0 kept", mem[0], pat(0));
    ctl_write(16'h0004);
    chk("R10 hv cleared keeps flags", 32'(ctl_rdata), 32'h604);
    ctl_write(16'h0005);
    chk("R10 restart needs interlock", 32'(ctl_rdata), 32'h604);
    chk("R10 no busy", 32'(erase_busy), 0);
    ctl_write(16'h0000);
    chk("R10 leave erase mode", 32'(ctl_rdata), 32'h600);
  endtask

  task automatic t_abandon();
    do_reset();
    slr_write(8'hFF, 8'h00);
    ctl_write(16'h0004);
    ilk_write();
    ctl_write(16'h0000);
    chk("R5 back to idle", 32'(ctl_rdata), 0);
    repeat (T_ERASE + 5) @(negedge clk);
    chk("R5 no commit", commit_cnt, 0);
    chk("R5 no busy time", busy_cnt, 0);
    chk("R5 sector0 kept", mem[0], pat(0));
  endtask

  task automatic t_abort();
    int n;
    do_reset();
    slr_write(8'hF0, 8'h00);
    ctl_write(16'h0004); ilk_write(); ctl_write(16'h0005);
    repeat (5) @(negedge clk);
    ctl_write(16'h0004);
    chk("R6 abort status", 32'(ctl_rdata), 32'h4);
    chk("R6 busy stops", 32'(erase_busy), 0);
    wait_done(n);
    chk("R6 abort latency", n, ABT_LAT);
    chk("R6 done without pass", 32'(ctl_rdata), 32'h404);
    @(negedge clk);
    chk("R6 no commit", commit_cnt, 0);
    chk("R6 sector4 untouched", mem[4], pat(4));
    ctl_write(16'h0005);
    chk("R6 new interlock needed", 32'(ctl_rdata), 32'h404);
  endtask

  task automatic t_suspend();
    int n;
    do_reset();
    slr_write(8'h03, 8'h00);
    ctl_write(16'h0004); ilk_write(); ctl_write(16'h0005);
    repeat (5) @(negedge clk);
    ctl_write(16'h0007);
    chk("R7 suspend flag", 32'(ctl_rdata), 32'h7);
    chk("R7 busy stops", 32'(erase_busy), 0);
    wait_done(n);
    chk("R7 suspend latency", n, SUS_LAT);
    chk("R7 within bound", 32'(n <= T_ESUS), 1);
    chk("R7 suspended status", 32'(ctl_rdata), 32'h407);
    ctl_write(16'h0006);
    chk("R8 abort ignored", 32'(ctl_rdata), 32'h407);
    ilk_write();
    repeat (10) @(negedge clk);
    chk("R8 still idle", 32'(erase_busy), 0);
    chk("R8 no commit", commit_cnt, 0);
    ctl_write(16'h0005);
    chk("R9 resume status", 32'(ctl_rdata), 32'h5);
    chk("R9 busy again", 32'(erase_busy), 1);
    wait_done(n);
    chk("R9 final status", 32'(ctl_rdata), 32'h605);
    @(negedge clk);
    chk("R9 total busy time", busy_cnt, T_ERASE);
    chk("R9 sector0 erased", mem[0], '1);
    chk("R9 sector2 kept", mem[2], pat(2));
  endtask

  task automatic t_guards();
    int n;
    do_reset();
    ctl_write(16'h0010);
    chk("R11 program bit", 32'(ctl_rdata), 32'h10);
    ctl_write(16'h0014);
    chk("R11 select blocked by program", 32'(ctl_rdata), 32'h10);
    ctl_write(16'h0000);
    ctl_write(16'h0002);
    chk("R11 suspend in idle", 32'(ctl_rdata), 0);
    ctl_write(16'h0004); ilk_write();
    ctl_write(16'h0006);
    chk("R11 suspend before start", 32'(ctl_rdata), 32'h4);
    ctl_write(16'h0005);
    wait_done(n);
    ctl_write(16'h0007);
    chk("R11 suspend after finish", 32'(ctl_rdata), 32'h605);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_abandon();
    t_abort();
    t_suspend();
    t_guards();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule